// File: doc/BRIEF.md
# Chainable Four-Bit Synchronous Counter with Split Enables

This block is a synchronous counter digit that is built to be chained. Each digit holds a count of `WIDTH` bits and counts either in binary (wrapping after all ones) or in decade steps (wrapping from 9 to 0). A parameter selects the counting mode. The clear, the parallel load and the counting all act on the rising clock edge. Every digit takes two active-high enables. A local enable pauses counting in this digit only. A chain enable also pauses counting, and in addition it gates the carry that the digit passes on to the next one.

The top level chains `STAGES` digits. The carry of each digit drives the chain enable of the digit above it. The local enable, the clear and the load are shared by all digits. With the default parameters, two decade digits form a modulus-100 BCD counter. The digits are packed with the least significant digit in bits [3:0]. The asynchronous active-low reset is released synchronously inside the block, and reset leaves every digit at zero.

Top module: `chain_counter`

## Requirements
- R1: After reset every digit reads zero and `carry_out` is low.
- R2: A digit changes its count on a clock edge only when both its local enable and its chain enable are high, or when clear or load is asserted. Otherwise it holds its value.
- R3: Clear sets all digits to zero on the next rising edge and has no effect before that edge. It takes priority over load and over counting.
- R4: Load copies `load_data` into the digits on the next rising edge. It takes priority over counting, and the loaded value stays for exactly that clock period unless the next cycle changes it.
- R5: A digit's carry is high exactly when its chain enable is high and its count equals the terminal value. The terminal value is 9 in decade mode and 15 in binary mode. The carry is combinational, with no clock delay.
- R6: The carry stays low whenever the chain enable is low, even at the terminal value.
- R7: An enabled count at the terminal value goes to 0 on the next edge: 9 to 0 in decade mode, 15 to 0 in binary mode.
- R8: In decade mode, a digit loaded with a value from 10 to 15 steps up by one on each enabled edge, and 15 goes to 0. It neither locks up nor raises a carry on those values.
- R9: In the default two-digit decade chain, the tens digit advances only on an enabled edge where the units digit is at 9. The chain goes from 99 to 00.
- R10: A binary digit loaded with 1 that reloads 1 whenever its count reaches 12 runs through a loop of 12 states. State 12 lasts one full clock period.
- R11: With the local enable low and the chain enable high, the digits hold their counts while the carry still follows the terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of all digits |
| load | input | 1 | Synchronous parallel load of all digits |
| load_data | input | STAGES*WIDTH | Value to load, least significant digit in the low bits |
| cnt_en | input | 1 | Local count enable, shared by all digits |
| chain_en | input | 1 | Chain enable of the lowest digit; also gates the carry |
| count | output | STAGES*WIDTH | Packed count of all digits |
| carry_out | output | 1 | Carry of the highest digit |

## Verification
The counting function is driven in several ways. Each enable is applied alone and then both together, which separates the two enables from each other. Clear, load and count are asserted together to show the priority order. The chain is run across 09→10 and 99→00 to show that the carry feeds the next digit. A decade digit is loaded with values from 10 to 15 to show that an out-of-range value drains back into the normal range without a carry. A separate binary digit runs a reload loop, which shows that a synchronous load gives modulus 12. The same digit also runs through 15 to show the binary terminal value and its wrap. The carry is sampled right after a change on the chain enable, with no clock edge in between, to show that it is combinational and that the chain enable gates it.

// File: rtl/chain_counter_pkg.sv
package chain_counter_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } digit_op_e;

  localparam int unsigned DECADE_LAST = 9;

endpackage

// File: rtl/reset_release.sv
module reset_release #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[DEPTH-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[DEPTH-1];

endmodule

// File: rtl/digit_ctrl.sv
module digit_ctrl
  import chain_counter_pkg::*;
(
  input  logic      clr,
  input  logic      load,
  input  logic      cnt_en,
  input  logic      chain_en,
  output digit_op_e op
);

  // Fixed priority: clear, then load, then count, else hold.
  always_comb begin
    if (clr) begin
      op = OP_CLEAR;
    end else if (load) begin
      op = OP_LOAD;
    end else if (cnt_en && chain_en) begin
      op = OP_COUNT;
    end else begin
      op = OP_HOLD;
    end
  end

endmodule

// File: rtl/count_digit.sv
module count_digit
  import chain_counter_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] data,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] count,
  output logic             carry
);

  localparam logic [WIDTH-1:0] LAST = DECADE ? WIDTH'(DECADE_LAST) : {WIDTH{1'b1}};

  digit_op_e        op;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             at_last;
  logic             upd_en;

  digit_ctrl u_ctrl (
    .clr      (clr),
    .load     (load),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  assign at_last = (count_q == LAST);
  assign upd_en  = (op != OP_HOLD);

  // Next value; plain increment also drains decade values 10..15 through the wrap.
  always_comb begin
    unique case (op)
      OP_CLEAR: count_d = '0;
      OP_LOAD:  count_d = data;
      OP_COUNT: count_d = at_last ? '0 : count_q + 1'b1;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (upd_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
  assign carry = chain_en && at_last;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && !load && !(cnt_en && chain_en)) |=> $stable(count));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count == '0));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (load && !clr) |=> (count == $past(data)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && !load && cnt_en && chain_en && count == LAST) |=> (count == '0));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && !load && cnt_en && chain_en && count != LAST)
      |=> (count == WIDTH'($past(count) + 1'b1)));

endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter bit          DECADE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      load,
  input  logic [STAGES*WIDTH-1:0]   load_data,
  input  logic                      cnt_en,
  input  logic                      chain_en,
  output logic [STAGES*WIDTH-1:0]   count,
  output logic                      carry_out
);

  localparam int unsigned TOTAL = STAGES * WIDTH;

  logic            rst_int_n;
  logic [STAGES:0] link_en;

  reset_release #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign link_en[0] = chain_en;

  for (genvar g = 0; g < STAGES; g++) begin : g_digit
    count_digit #(
      .WIDTH  (WIDTH),
      .DECADE (DECADE)
    ) u_digit (
      .clk      (clk),
      .rst_ni   (rst_int_n),
      .clr      (clr),
      .load     (load),
      .data     (load_data[g*WIDTH +: WIDTH]),
      .cnt_en   (cnt_en),
      .chain_en (link_en[g]),
      .count    (count[g*WIDTH +: WIDTH]),
      .carry    (link_en[g+1])
    );
  end

  assign carry_out = link_en[STAGES];

  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !chain_en |-> !carry_out);

  assert_top_wrap_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clr && !load && cnt_en && carry_out) |=> (count == TOTAL'(0)));

endmodule

// File: tb/chain_counter_test.sv
module chain_counter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr, load, cnt_en, chain_en;
  logic [7:0] load_data;
  logic [7:0] count;
  logic       carry_out;

  logic       b_clr, b_load, b_cnt_en, b_chain_en;
  logic [3:0] b_data;
  logic [3:0] b_count;
  logic       b_carry;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  chain_counter #(.WIDTH(4), .STAGES(2), .DECADE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(load_data),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(count), .carry_out(carry_out)
  );

  chain_counter #(.WIDTH(4), .STAGES(1), .DECADE(1'b0)) uut_bin (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .load(b_load), .load_data(b_data),
    .cnt_en(b_cnt_en), .chain_en(b_chain_en), .count(b_count), .carry_out(b_carry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr = 0; load = 0; cnt_en = 0; chain_en = 0; load_data = 8'h00;
    b_clr = 0; b_load = 0; b_cnt_en = 0; b_chain_en = 0; b_data = 4'h0;
    step(3);
    rst_n = 1'b1;
    step(3);
    chk("R1 count", count, 8'h00);
    chk("R1 carry", carry_out, 0);
    chk("R1 bin count", b_count, 0);
  endtask

  task automatic t_enables;
    cnt_en = 1; chain_en = 0;
    step(3);
    chk("R2 local only", count, 8'h00);
    cnt_en = 0; chain_en = 1;
    step(2);
    chk("R2 chain only", count, 8'h00);
    cnt_en = 1;
    step(3);
    chk("R2 both", count, 8'h03);
  endtask

  task automatic t_chain;
    load = 1; load_data = 8'h05;
    step(1);
    load = 0;
    chk("R4 load", count, 8'h05);
    step(4);
    chk("R2 count to 9", count, 8'h09);
    chk("R9 no top carry at 09", carry_out, 0);
    step(1);
    chk("R9 09 to 10", count, 8'h10);
    load = 1; load_data = 8'h98;
    step(1);
    load = 0;
    step(1);
    chk("R9 reach 99", count, 8'h99);
    chk("R5 carry at 99", carry_out, 1);
    chain_en = 0;
    #1;
    chk("R6 carry gated", carry_out, 0);
    step(1);
    chk("R6 hold when gated", count, 8'h99);
    chk("R6 carry still low", carry_out, 0);
    chain_en = 1; cnt_en = 0;
    #1;
    chk("R11 carry with local off", carry_out, 1);
    step(2);
    chk("R11 hold", count, 8'h99);
    cnt_en = 1;
    step(1);
    chk("R7 R9 99 to 00", count, 8'h00);
    chk("R9 carry drops", carry_out, 0);
  endtask

  task automatic t_priority;
    load = 1; load_data = 8'h42;
    step(1);
    load = 0; cnt_en = 0;
    clr = 1;
    #2;
    chk("R3 clear waits for edge", count, 8'h42);
    load = 1; load_data = 8'h77; cnt_en = 1;
    step(1);
    chk("R3 clear wins", count, 8'h00);
    clr = 0; load_data = 8'h31;
    step(1);
    chk("R4 load over count", count, 8'h31);
    load = 0;
    step(1);
    chk("R4 then counts", count, 8'h32);
  endtask

  task automatic t_out_of_range;
    load = 1; load_data = 8'h0C;
    step(1);
    load = 0;
    chk("R8 loaded C", count, 8'h0C);
    step(1);
    chk("R8 C to D", count, 8'h0D);
    step(2);
    chk("R8 reach F", count, 8'h0F);
    chk("R8 no carry at F", carry_out, 0);
    step(1);
    chk("R8 F to 0 no tens step", count, 8'h00);
    step(1);
    chk("R8 normal after drain", count, 8'h01);
  endtask

  task automatic t_binary;
    int first_one;
    first_one = -1;
    b_chain_en = 1; b_cnt_en = 1;
    b_load = 1; b_data = 4'd14;
    step(1);
    b_load = 0;
    chk("R5 bin no carry at 14", b_carry, 0);
    step(1);
    chk("R5 bin at 15", b_count, 15);
    chk("R5 bin carry at 15", b_carry, 1);
    step(1);
    chk("R7 bin 15 to 0", b_count, 0);
    b_load = 1; b_data = 4'd1;
    step(1);
    chk("R10 start", b_count, 1);
    for (int i = 1; i <= 30; i++) begin
      b_load = (b_count == 4'd12);
      step(1);
      if (b_count == 4'd1 && first_one < 0) first_one = i;
      if (i == 11) chk("R10 state 12 reached", b_count, 12);
    end
    b_load = 0;
    chk("R10 loop length", first_one, 12);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enables();
    t_chain();
    t_priority();
    t_out_of_range();
    t_binary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule